// File: doc/BRIEF.md
# Sync-Paced Display Identity Streamer

This block lets a display announce a fixed 128-byte identity record to a host over one data wire, with no request from the host and no return path. The host's vertical-sync pulses serve as the bit clock. Each rising edge of sync moves the serial line forward by one position, so the bit rate equals the frame rate, typically 60 to 100 bits per second. When the last byte has been sent, transmission wraps to the first byte, and the record repeats for as long as sync keeps running.

Sync arrives from outside the system clock domain. It passes through a synchroniser, and a rising-edge detector turns each sync rise into a single step of the sequencer. Each byte takes nine sync periods: eight data bits, most significant bit first, followed by a framing slot that is always high. The identity bytes are held in a read-only table whose contents come from a packed parameter. Two outputs help an observer locate its position in the stream: the index of the byte being sent, and a one-cycle pulse that marks the start of byte 0.

Top module: `vsid_streamer`

## Requirements
- R1: While reset is active, and after reset until the first detected sync rise, `sdata` is 1, `byte_idx` is 0 and `sob` is 0.
- R2: A rise on `vsync` passes through a two-flop synchroniser. The outputs change on the third rising clock edge after `vsync` is first sampled high, and do not change before that edge.
- R3: The stream advances by exactly one position per rising edge of `vsync`. A high or low level held for any length of time has no effect, and neither does a falling edge.
- R4: The first sync rise after reset places bit 7 of byte 0 on `sdata`. Each later rise within a byte presents the next lower bit, so the bits of a byte appear in the order 7 down to 0.
- R5: After bit 0 of each byte, the next rise presents a framing slot in which `sdata` is 1. Every byte therefore occupies 9 sync periods.
- R6: After the framing slot of byte 127, the next rise presents bit 7 of byte 0, and the sequence repeats without end.
- R7: `sob` is high for exactly one clock cycle, in the cycle in which `sdata` first carries bit 7 of byte 0. This applies both after reset and on every wrap.
- R8: `byte_idx` gives the index of the byte whose data bits or framing slot is currently on `sdata`.
- R9: With the default parameters, byte i of the table equals (29·i + 60) mod 256. For example, byte 0 is 0x3C, byte 1 is 0x59 and byte 127 is 0x9F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-assert, active-low reset |
| vsync | input | 1 | Vertical sync from the host side; not synchronous to `clk` |
| sdata | output | 1 | Serial identity data line |
| byte_idx | output | $clog2(N_BYTES) | Index of the byte currently being sent |
| sob | output | 1 | One-cycle pulse when byte 0 begins |

## Verification
The case that matters most is the wrap. On a single sync step, the framing slot of the last byte ends, the byte index falls back to zero, bit 7 of byte 0 is loaded and the start-of-block pulse fires, all in the same cycle. The bench reaches this point by clocking two complete passes through the table. At the wrap it checks that the index reads 0 in the step that follows the framing slot of byte 127, and that over the two passes exactly two start pulses appeared, one per pass. A second overlap is the very first step after reset, where leaving the idle state coincides with the start pulse. That step is checked cycle by cycle against the synchroniser latency.

// File: rtl/vsid_pkg.sv
package vsid_pkg;

  localparam int unsigned IMG_BYTES  = 128;
  localparam int unsigned FRAME_SLOT = 8;
  localparam int unsigned SLOT_W     = 4;

  // Default identity byte for table position i
  function automatic logic [7:0] image_byte(int unsigned i);
    return 8'((i * 29 + 60) % 256);
  endfunction

  // Pack the default table, byte i at bits [8i+7:8i]
  function automatic logic [IMG_BYTES*8-1:0] make_image();
    logic [IMG_BYTES*8-1:0] img;
    img = '0;
    for (int unsigned i = 0; i < IMG_BYTES; i++) begin
      img[i*8 +: 8] = image_byte(i);
    end
    return img;
  endfunction

  // Line value for a slot: data slots 0..7 carry bit 7..0, slot 8 is framing
  function automatic logic slot_bit(logic [7:0] b, logic [SLOT_W-1:0] slot);
    if (slot >= SLOT_W'(FRAME_SLOT)) return 1'b1;
    return b[3'(4'd7 - slot)];
  endfunction

endpackage

// File: rtl/vsid_edge_sync.sv
module vsid_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/vsid_rom.sv
module vsid_rom #(
  parameter int unsigned          N_BYTES = 128,
  parameter int unsigned          IDX_W   = 7,
  parameter logic [N_BYTES*8-1:0] IMAGE   = '0
) (
  input  logic [IDX_W-1:0] addr,
  output logic [7:0]       data
);

  logic [7:0] table_w [N_BYTES];

  for (genvar g = 0; g < N_BYTES; g++) begin : g_entry
    assign table_w[g] = IMAGE[g*8 +: 8];
  end

  assign data = (32'(addr) < N_BYTES) ? table_w[addr] : 8'hFF;

endmodule

// File: rtl/vsid_sequencer.sv
module vsid_sequencer
  import vsid_pkg::*;
#(
  parameter int unsigned N_BYTES = 128,
  parameter int unsigned IDX_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [7:0]        rd_data,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              sdata,
  output logic [IDX_W-1:0]  byte_idx,
  output logic              sob,
  output logic [SLOT_W-1:0] slot,
  output logic              wrap_evt
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

  logic              active_q;
  logic [IDX_W-1:0]  byte_q;
  logic [SLOT_W-1:0] slot_q;
  logic              byte_done;
  logic [IDX_W-1:0]  next_byte;
  logic [SLOT_W-1:0] next_slot;

  assign byte_done = active_q && (slot_q == SLOT_W'(FRAME_SLOT));

  always_comb begin
    next_byte = (byte_q == LAST) ? '0 : byte_q + 1'b1;
    next_slot = (!active_q || byte_done) ? '0 : slot_q + 1'b1;
    if (!active_q)     rd_addr = '0;
    else if (byte_done) rd_addr = next_byte;
    else               rd_addr = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      byte_q   <= '0;
      slot_q   <= '0;
      sdata    <= 1'b1;
      sob      <= 1'b0;
    end else begin
      sob <= 1'b0;
      if (step) begin
        active_q <= 1'b1;
        slot_q   <= next_slot;
        byte_q   <= byte_done ? next_byte : byte_q;
        sdata    <= slot_bit(rd_data, next_slot);
        sob      <= !active_q || (byte_done && next_byte == '0);
      end
    end
  end

  assign byte_idx = byte_q;
  assign slot     = slot_q;
  assign wrap_evt = step && byte_done && (byte_q == LAST);

endmodule

// File: rtl/vsid_streamer.sv
module vsid_streamer
  import vsid_pkg::*;
#(
  parameter int unsigned          N_BYTES     = IMG_BYTES,
  parameter int unsigned          SYNC_STAGES = 2,
  parameter logic [N_BYTES*8-1:0] ROM_IMAGE   = make_image()
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vsync,
  output logic                       sdata,
  output logic [$clog2(N_BYTES)-1:0] byte_idx,
  output logic                       sob
);

  localparam int unsigned IDX_W = $clog2(N_BYTES);

  logic              vsync_rise;
  logic [IDX_W-1:0]  rom_addr;
  logic [7:0]        rom_data;
  logic [SLOT_W-1:0] slot_w;
  logic              wrap_w;

  vsid_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (vsync),
    .rise     (vsync_rise)
  );

  vsid_rom #(.N_BYTES(N_BYTES), .IDX_W(IDX_W), .IMAGE(ROM_IMAGE)) rom_i (
    .addr (rom_addr),
    .data (rom_data)
  );

  vsid_sequencer #(.N_BYTES(N_BYTES), .IDX_W(IDX_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (vsync_rise),
    .rd_data  (rom_data),
    .rd_addr  (rom_addr),
    .sdata    (sdata),
    .byte_idx (byte_idx),
    .sob      (sob),
    .slot     (slot_w),
    .wrap_evt (wrap_w)
  );

endmodule

// File: rtl/vsid_streamer_chk.sv
module vsid_streamer_chk #(
  parameter int unsigned N_BYTES = 128,
  parameter int unsigned IDX_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             sdata,
  input logic [IDX_W-1:0] byte_idx,
  input logic             sob,
  input logic [3:0]       slot,
  input logic             wrap_evt
);

  // R3
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(sdata));

  // R8
  hold_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(byte_idx));

  // R5
  frame_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 4'd8) |-> sdata);

  // R7
  sob_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sob |-> $past(step));

  // R7
  sob_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sob |-> (byte_idx == '0 && slot == 4'd0));

  // R7
  sob_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sob |=> !sob);

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (byte_idx == '0 && sob));

  // R8
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(byte_idx) < N_BYTES);

endmodule

bind vsid_streamer vsid_streamer_chk #(.N_BYTES(N_BYTES), .IDX_W($clog2(N_BYTES))) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (vsync_rise),
  .sdata    (sdata),
  .byte_idx (byte_idx),
  .sob      (sob),
  .slot     (slot_w),
  .wrap_evt (wrap_w)
);

// File: tb/vsid_streamer_tb_top.sv
module vsid_streamer_tb_top;

  localparam int NB = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync = 1'b0;
  logic       sdata;
  logic [6:0] byte_idx;
  logic       sob;

  int checks = 0;
  int errors = 0;
  int sob_cnt = 0;
  bit done = 1'b0;

  // Expected {sdata, byte_idx} after sync edges 2..18 following reset
  localparam logic [7:0] VEC [17] = '{
    8'h00, 8'h80, 8'h80, 8'h80, 8'h80, 8'h00, 8'h00, 8'h80,
    8'h01, 8'h81, 8'h01, 8'h81, 8'h81, 8'h01, 8'h01, 8'h81,
    8'h81
  };

  always #4 clk = ~clk;

  vsid_streamer dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsync    (vsync),
    .sdata    (sdata),
    .byte_idx (byte_idx),
    .sob      (sob)
  );

  always @(negedge clk) if (sob) sob_cnt++;

  function automatic logic [7:0] ref_byte(int i);
    int v;
    v = 60;
    for (int k = 0; k < i; k++) v = (v + 29) & 255;
    return 8'(v);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk) vsync = 1'b1;
    repeat (hi) @(negedge clk);
    vsync = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    vsync = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] acc;
    do_reset();
    // R1 reset state
    check(sdata == 1'b1 && byte_idx == 0 && sob == 1'b0, "R1 reset state",
          {sdata, byte_idx, sob}, 9'h100);
    // R3 held low: no advance
    repeat (20) @(negedge clk);
    check(sdata == 1'b1 && byte_idx == 0, "R3 idle low", sdata, 1);

    // R2/R10/R7 first edge latency
    @(negedge clk) vsync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(sdata == 1'b1 && sob == 1'b0, "R2 no change before third edge", sdata, 1);
    @(negedge clk);
    check(sdata == 1'b0, "R4 first bit is bit7 of byte0 (R2 latency)", sdata, 0);
    check(sob == 1'b1, "R7 sob at start of byte0", sob, 1);
    @(negedge clk);
    check(sob == 1'b0, "R7 sob one cycle", sob, 0);
    // R3 long high then falling edge: no further advance
    repeat (15) @(negedge clk);
    vsync = 1'b0;
    repeat (10) @(negedge clk);
    check(sdata == 1'b0 && byte_idx == 0, "R3 level and falling edge ignored", sdata, 0);

    // Vector table walk, alternating pulse shapes (R3 R4 R5 R8 R9)
    for (int v = 0; v < 17; v++) begin
      if (v % 2 == 0) pulse(5, 7);
      else            pulse(20, 3);
      check(sdata == VEC[v][7] && byte_idx == VEC[v][6:0],
            "R4/R5/R8 vector step", {sdata, byte_idx}, VEC[v]);
    end

    // Full two-pass rebuild from a fresh reset
    do_reset();
    check(sdata == 1'b1 && byte_idx == 0 && sob == 1'b0, "R1 second reset",
          {sdata, byte_idx, sob}, 9'h100);
    base = sob_cnt;
    acc = '0;
    for (int k = 0; k < 2 * NB * 9; k++) begin
      int slot_n;
      int byte_n;
      pulse(4, 4);
      slot_n = k % 9;
      byte_n = (k / 9) % NB;
      if (byte_idx != 7'(byte_n))
        check(1'b0, "R8 byte index", byte_idx, byte_n);
      if (slot_n < 8) begin
        acc = {acc[6:0], sdata};
      end else begin
        check(sdata == 1'b1, "R5 framing slot high", sdata, 1);
        check(acc == ref_byte(byte_n), "R9 rebuilt byte", acc, ref_byte(byte_n));
      end
      if (k == NB * 9)
        check(byte_idx == 0 && sdata == ref_byte(0)[7], "R6 wrap to byte0",
              {sdata, byte_idx}, {ref_byte(0)[7], 7'd0});
    end
    check(sob_cnt - base == 2, "R7 one sob per pass (R6)", sob_cnt - base, 2);
    check(ref_byte(127) == 8'h9F, "R9 table end value", ref_byte(127), 8'h9F);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule